// File: doc/BRIEF.md
# Banked Single-Port RAM with Selectable Write-Cycle Output

This block is a deep single-clock memory assembled from a chain of equal RAM banks. The user drives one flat address space. Inside, the upper address bits choose one bank and the lower bits choose the word inside it. On every access only the chosen bank receives its enable. The other banks stay idle, which keeps dynamic activity close to that of a single small RAM.

The port carries an access enable, a write enable, an address and write data, and it returns registered read data one clock after the access. A parameter fixes what the read output shows on a write cycle. It can keep its previous value, which is the default. It can show the word being written. Or it can show the word the location held before the write. When the access enable is low, the memory neither reads nor writes, and the output keeps its value. A diagnostic output reports every bank enable, and a flag reports any cycle on which more than one bank would be enabled.

The bank count must be 1, 2, 4 or 8, with a default of 4. The bank depth must be a power of two. The port is a plain memory port with no back-pressure: an access is accepted on every clock edge where the enable is high.

Top module: `cascade_ram`

## Requirements
- R1: The word is selected by addr[BANK_AW-1:0] and the bank by addr[ADDR_W-1:BANK_AW]. A read with en=1, we=0 presents the stored word on rdata after the next rising clock edge, and rdata holds it until a later edge changes it.
- R2: bank_act has one bit per bank. Bit k is 1 exactly when en=1 and the bank field of addr equals k. At most one bit is ever set.
- R3: With en=0, no bank is enabled (bank_act=0) and rdata keeps its value across the edge.
- R4: With WMODE=WM_HOLD (value 0, the default), a write cycle leaves rdata unchanged. This holds even when the write targets a bank other than the one last read.
- R5: With WMODE=WM_WRITE_FIRST (value 1), rdata shows wdata after a write cycle.
- R6: With WMODE=WM_READ_FIRST (value 2), rdata shows the word the location held before the write.
- R7: After reset, rdata is 0.
- R8: sel_err is 1 only when more than one bank enable is set. In correct operation it stays 0.
- R9: we has no effect when en=0. The addressed word keeps its contents, as a later read shows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the output path |
| en | input | 1 | Access enable; gates reads and writes |
| we | input | 1 | Write enable, effective only with en |
| addr | input | ADDR_W | Flat word address (bank field on top) |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data |
| bank_act | output | NUM_BANKS | Per-bank enable, for observation |
| sel_err | output | 1 | Set when more than one bank enable is active |

## Verification
Embedded assertions check on every cycle that at most one bank enable is set and that none is set while idle. They also check that the output holds while idle, that the hold-mode output is stable on writes, that the write-first output equals the previous write data, and that the error flag stays low. Stored contents, read-first values and the fact that a disabled write leaves memory untouched can only be shown by bench scenarios. These compare three instances, one per write mode, against a behavioural model over a full fill, directed bank-switch cases and random traffic.

// File: rtl/cram_pkg.sv
package cram_pkg;
  typedef enum logic [1:0] {
    WM_HOLD        = 2'd0,
    WM_WRITE_FIRST = 2'd1,
    WM_READ_FIRST  = 2'd2
  } wmode_e;
endpackage

// File: rtl/cram_decoder.sv
module cram_decoder #(
  parameter int NB    = 4,
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [SEL_W-1:0] idx,
  output logic [NB-1:0]    bank_en
);
  genvar k;
  generate
    for (k = 0; k < NB; k++) begin : g_dec
      assign bank_en[k] = en && (idx == SEL_W'(k));
    end
  endgenerate

  // R2
  onehot_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_en));

  // R3
  idle_no_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (bank_en == '0));
endmodule

// File: rtl/cram_bank.sv
module cram_bank
  import cram_pkg::*;
#(
  parameter int     DW    = 16,
  parameter int     AW    = 6,
  parameter wmode_e WMODE = WM_HOLD
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] dout
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en && we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout <= '0;
    end else if (en) begin
      if (!we) begin
        dout <= mem[waddr];
      end else begin
        case (WMODE)
          WM_WRITE_FIRST: dout <= wdata;
          WM_READ_FIRST:  dout <= mem[waddr];
          default:        dout <= dout;
        endcase
      end
    end
  end

  // R3
  bank_idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(dout));

  generate
    if (WMODE == WM_WRITE_FIRST) begin : g_wf_chk
      // R5
      bank_wf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && we) |=> (dout == $past(wdata)));
    end
  endgenerate
endmodule

// File: rtl/cram_outmux.sv
module cram_outmux #(
  parameter int NB    = 4,
  parameter int SEL_W = 2,
  parameter int DW    = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 capture,
  input  logic [SEL_W-1:0]     idx,
  input  logic [NB-1:0][DW-1:0] bank_dout,
  output logic [DW-1:0]        rdata
);
  generate
    if (NB == 1) begin : g_single
      assign rdata = bank_dout[0];
    end else begin : g_multi
      logic [SEL_W-1:0] sel_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       sel_q <= '0;
        else if (capture) sel_q <= idx;
      end
      assign rdata = bank_dout[sel_q];
    end
  endgenerate
endmodule

// File: rtl/cascade_ram.sv
module cascade_ram
  import cram_pkg::*;
#(
  parameter int     NUM_BANKS  = 4,
  parameter int     BANK_DEPTH = 64,
  parameter int     DATA_W     = 16,
  parameter wmode_e WMODE      = WM_HOLD,
  localparam int    BANK_AW    = $clog2(BANK_DEPTH),
  localparam int    IDX_W      = $clog2(NUM_BANKS),
  localparam int    ADDR_W     = BANK_AW + IDX_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic                 we,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [DATA_W-1:0]    wdata,
  output logic [DATA_W-1:0]    rdata,
  output logic [NUM_BANKS-1:0] bank_act,
  output logic                 sel_err
);
  localparam int SEL_W = (IDX_W == 0) ? 1 : IDX_W;

  logic [SEL_W-1:0]                   idx;
  logic [BANK_AW-1:0]                 word;
  logic [NUM_BANKS-1:0][DATA_W-1:0]   bank_dout;
  logic                               capture;

  generate
    if (IDX_W == 0) begin : g_noidx
      assign idx = '0;
    end else begin : g_idx
      assign idx = addr[ADDR_W-1:BANK_AW];
    end
  endgenerate
  assign word = addr[BANK_AW-1:0];

  cram_decoder #(.NB(NUM_BANKS), .SEL_W(SEL_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .en(en), .idx(idx), .bank_en(bank_act)
  );

  genvar b;
  generate
    for (b = 0; b < NUM_BANKS; b++) begin : g_bank
      cram_bank #(.DW(DATA_W), .AW(BANK_AW), .WMODE(WMODE)) u_bank (
        .clk(clk), .rst_n(rst_n), .en(bank_act[b]), .we(we),
        .waddr(word), .wdata(wdata), .dout(bank_dout[b])
      );
    end
  endgenerate

  // The select register follows only accesses that change the output.
  assign capture = en && (!we || (WMODE != WM_HOLD));

  cram_outmux #(.NB(NUM_BANKS), .SEL_W(SEL_W), .DW(DATA_W)) u_mux (
    .clk(clk), .rst_n(rst_n), .capture(capture), .idx(idx),
    .bank_dout(bank_dout), .rdata(rdata)
  );

  assign sel_err = ($countones(bank_act) > 1);

  // R8
  no_sel_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_err);

  // R3
  idle_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(rdata));

  generate
    if (WMODE == WM_HOLD) begin : g_hold_chk
      // R4
      hold_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && we) |=> $stable(rdata));
    end
  endgenerate
endmodule

// File: tb/sim_cascade_ram.sv
module sim_cascade_ram;
  import cram_pkg::*;
  localparam int NB = 4, DEPTH = 64, DW = 16, AW = 8, WORDS = NB * DEPTH;

  logic clk = 0, rst_n = 0, en = 0, we = 0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rd [3];
  logic [NB-1:0] act [3];
  logic          err [3];

  always #10 clk = ~clk;

  cascade_ram #(.WMODE(WM_HOLD)) u0 (.clk(clk), .rst_n(rst_n), .en(en), .we(we),
    .addr(addr), .wdata(wdata), .rdata(rd[0]), .bank_act(act[0]), .sel_err(err[0]));
  cascade_ram #(.WMODE(WM_WRITE_FIRST)) u_wf (.clk(clk), .rst_n(rst_n), .en(en), .we(we),
    .addr(addr), .wdata(wdata), .rdata(rd[1]), .bank_act(act[1]), .sel_err(err[1]));
  cascade_ram #(.WMODE(WM_READ_FIRST)) u_rf (.clk(clk), .rst_n(rst_n), .en(en), .we(we),
    .addr(addr), .wdata(wdata), .rdata(rd[2]), .bank_act(act[2]), .sel_err(err[2]));

  int checks = 0, errors = 0;
  logic [DW-1:0] model [WORDS];
  logic [DW-1:0] expd [3];
  bit done = 0;

  function automatic logic [NB-1:0] exp_act(logic e, logic [AW-1:0] a);
    return e ? (NB'(1) << a[AW-1:AW-2]) : '0;
  endfunction

  task automatic chk(bit ok, string tag, int act_v, int exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act_v, exp_v);
    end
  endtask

  task automatic op(logic e, logic w, logic [AW-1:0] a, logic [DW-1:0] d, string tag);
    @(negedge clk);
    en = e; we = w; addr = a; wdata = d;
    #1;
    for (int m = 0; m < 3; m++) begin
      chk(act[m] == exp_act(e, a), "R2 bank_act", act[m], exp_act(e, a));
      chk(err[m] == 1'b0, "R8 sel_err", err[m], 0);
    end
    if (e) begin
      if (!w) begin
        for (int m = 0; m < 3; m++) expd[m] = model[a];
      end else begin
        expd[1] = d;
        expd[2] = model[a];
        model[a] = d;
      end
    end
    @(posedge clk); #1;
    for (int m = 0; m < 3; m++)
      chk(rd[m] == expd[m], tag, rd[m], expd[m]);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    for (int m = 0; m < 3; m++) begin
      chk(rd[m] == '0, "R7 reset rdata", rd[m], 0);
      expd[m] = '0;
    end
    // fill every word (R5/R6 on write cycles, R4 hold)
    for (int i = 0; i < WORDS; i++)
      op(1, 1, AW'(i), DW'(i * 37 + 5), "R4/R5/R6 fill write");
    for (int i = 0; i < WORDS; i++)
      op(1, 0, AW'(i), '0, "R1 read back");
    // R4: read bank 0, then write bank 3: hold output must not switch bank
    op(1, 0, 8'h05, '0, "R1 read bank0");
    op(1, 1, 8'hC5, 16'hBEEF, "R4 write other bank");
    op(0, 0, 8'hC5, '0, "R3 idle");
    op(1, 0, 8'hC5, '0, "R1 read bank3");
    // R9: disabled write leaves memory untouched
    op(0, 1, 8'h42, 16'hDEAD, "R9 disabled write");
    op(0, 1, 8'h81, 16'hDEAD, "R3 idle hold");
    op(1, 0, 8'h42, '0, "R9 word unchanged");
    op(1, 0, 8'h81, '0, "R9 word unchanged");
    // R6 read-first on top and bottom words
    op(1, 1, 8'hFF, 16'h1234, "R6 write top");
    op(1, 1, 8'hFF, 16'h5678, "R6 rewrite top");
    op(1, 1, 8'h00, 16'hA5A5, "R5 write bottom");
    // random traffic
    for (int i = 0; i < 3000; i++) begin
      logic e, w;
      e = ($urandom % 10) < 8;
      w = $urandom % 2;
      op(e, w, AW'($urandom), DW'($urandom), "R1/R3/R4/R5/R6 random");
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule